// File: doc/BRIEF.md
# Memory Protection Region Checker

This block sits in front of a processor's memory bus and decides, for each instruction fetch, read or write, whether it may proceed. It holds a table of protection regions. Software loads them through a simple write port, one region per write. Each region has an enable bit, a base address, a power-of-two size code, a mask of eight subregion disables, four permission bits and an execute-never flag. Two global control bits complete the setup. One switches the whole unit on. The other lets privileged code reach addresses that no region covers.

Each cycle that an access is presented, the block looks up every region in parallel. When several regions match, the highest-numbered one wins. The block then checks the access against that region's permissions. One clock later it returns a registered result: a valid strobe, a fault flag, a hit flag and the winning region number. The fault flag goes to the exception logic, which is outside this block. Region bases are expected to be aligned to their size; the matcher ignores the low address bits, so a misaligned base behaves like its aligned-down value.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset, every region is disabled, the unit is disabled, background access is off and res_valid is 0.
- R2: While the unit enable bit is 0, every access gets res_fault=0, res_hit=0 and res_region=0, whatever the region table holds.
- R3: A size code N stands for 2^(N+1) bytes. A region takes part in matching only when its enable bit is 1 and N is 4 or more; a code below 4 makes the region inert.
- R4: A region matches when the access address and the base agree in every bit above bit N. Base bits at or below bit N are ignored.
- R5: When N is 7 or more, address bits [N:N-2] give the subregion index. A mask bit i of 1 makes subregion i not match.
- R6: When N is below 7, the subregion mask has no effect on matching.
- R7: When more than one region matches, the highest-numbered one sets the outcome. res_hit=1 and res_region gives its number.
- R8: The permission bits of the winning region are: bit0 privileged read, bit1 privileged write, bit2 unprivileged read, bit3 unprivileged write. The access type is coded as 0 read, 1 write, 2 or 3 fetch. A read needs the read bit of its level, a write needs the write bit, and a fetch needs the read bit. Otherwise res_fault=1.
- R9: A fetch that wins a region with execute-never set faults, even when reads are allowed there.
- R10: With the unit enabled and no region matching: an unprivileged access faults. A privileged access is allowed when the background bit is 1 and faults when it is 0. In both cases res_hit=0 and res_region=0.
- R11: The result appears on the clock edge after the access is presented: res_valid equals the previous cycle's acc_valid. Both res_fault and res_hit are 0 whenever res_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the two global control bits |
| ctl_unit_en | input | 1 | Unit enable value to write |
| ctl_bg_en | input | 1 | Privileged background access value to write |
| cfg_we | input | 1 | Region write strobe |
| cfg_idx | input | IDX_W | Region number to write |
| cfg_en | input | 1 | Region enable |
| cfg_base | input | ADDR_W | Region base address |
| cfg_size | input | 5 | Size code N, size is 2^(N+1) bytes |
| cfg_subdis | input | 8 | Subregion disable mask |
| cfg_perm | input | 4 | Permission bits (privileged rd/wr, unprivileged rd/wr) |
| cfg_xn | input | 1 | Execute-never flag |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_type | input | 2 | 0 read, 1 write, 2 or 3 fetch |
| acc_priv | input | 1 | 1 for privileged code |
| res_valid | output | 1 | Result valid, one cycle after the access |
| res_fault | output | 1 | Access violates protection |
| res_hit | output | 1 | Some region matched |
| res_region | output | IDX_W | Winning region number, 0 on no hit |

## Verification
The directed cases probe the edges of the size and subregion decode. They use a 32-byte region at its last byte and the first byte past it, a size code of 3 that must stay inert, and a misaligned base. They also cover a 256-byte region with one subregion masked out, and a 128-byte region whose full mask must be ignored. A decoder off by one in the shift would either miss the last byte or hit the next one. A subregion index taken from the wrong bits would block the neighbouring slice rather than the masked one. Overlap tests put a small permissive region inside a large restrictive one; reversed priority shows up as a false fault. Random tables with overlapping regions and mixed levels, types and execute-never flags then compare every result against a bench model. This catches swapped permission bits, fetches that ignore execute-never, and a privileged miss that does not follow the background bit.

// File: rtl/mpu_pkg.sv
// Shared encodings for the region checker: access types, permission bit
// positions and size-code limits. Assumes size codes are 5 bits wide.
package mpu_pkg;

    localparam int SIZE_W      = 5;
    localparam int SUB_COUNT   = 8;
    localparam int PERM_W      = 4;

    // smallest legal size code (32 bytes) and smallest code with subregions (256 bytes)
    localparam logic [SIZE_W-1:0] SIZE_MIN   = 5'd4;
    localparam logic [SIZE_W-1:0] SUBREG_MIN = 5'd7;

    // permission bit positions
    localparam int P_PRIV_RD = 0;
    localparam int P_PRIV_WR = 1;
    localparam int P_USER_RD = 2;
    localparam int P_USER_WR = 3;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    // Decide whether an access of the given kind is allowed by a region.
    function automatic logic access_allowed(
        input logic [PERM_W-1:0] perm,
        input logic              xn,
        input logic              priv,
        input logic [1:0]        kind
    );
        logic rd_ok;
        logic wr_ok;
        rd_ok = priv ? perm[P_PRIV_RD] : perm[P_USER_RD];
        wr_ok = priv ? perm[P_PRIV_WR] : perm[P_USER_WR];
        if (kind[1])
            return rd_ok && !xn;
        else if (kind == ACC_WRITE)
            return wr_ok;
        else
            return rd_ok;
    endfunction

endpackage

// File: rtl/mpu_region_table.sv
// Storage for the region descriptors. One region is written per cycle
// through the cfg port; all regions are read in parallel. Assumes
// NUM_REGIONS is a power of two so every index value names a region.
module mpu_region_table
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [IDX_W-1:0]                    cfg_idx,
    input  logic                                cfg_en,
    input  logic [ADDR_W-1:0]                   cfg_base,
    input  logic [SIZE_W-1:0]                   cfg_size,
    input  logic [SUB_COUNT-1:0]                cfg_subdis,
    input  logic [PERM_W-1:0]                   cfg_perm,
    input  logic                                cfg_xn,
    output logic [NUM_REGIONS-1:0]              tbl_en,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]  tbl_base,
    output logic [NUM_REGIONS-1:0][SIZE_W-1:0]  tbl_size,
    output logic [NUM_REGIONS-1:0][SUB_COUNT-1:0] tbl_subdis,
    output logic [NUM_REGIONS-1:0][PERM_W-1:0]  tbl_perm,
    output logic [NUM_REGIONS-1:0]              tbl_xn
);

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
        // Load one descriptor slot when its index is written; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tbl_en[g]     <= 1'b0;
                tbl_base[g]   <= '0;
                tbl_size[g]   <= '0;
                tbl_subdis[g] <= '0;
                tbl_perm[g]   <= '0;
                tbl_xn[g]     <= 1'b0;
            end else if (cfg_we && cfg_idx == IDX_W'(g)) begin
                tbl_en[g]     <= cfg_en;
                tbl_base[g]   <= cfg_base;
                tbl_size[g]   <= cfg_size;
                tbl_subdis[g] <= cfg_subdis;
                tbl_perm[g]   <= cfg_perm;
                tbl_xn[g]     <= cfg_xn;
            end
        end
    end

endmodule

// File: rtl/mpu_region_match.sv
// Address matcher for a single region. Compares only the address bits
// above the region size and applies the subregion mask for regions of
// 256 bytes and up. Purely combinational.
module mpu_region_match
    import mpu_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 en,
    input  logic [ADDR_W-1:0]    base,
    input  logic [SIZE_W-1:0]    size,
    input  logic [SUB_COUNT-1:0] subdis,
    input  logic [ADDR_W-1:0]    addr,
    output logic                 hit
);

    logic [SIZE_W:0]   hi_shift;
    logic [ADDR_W-1:0] upper_diff;
    logic [2:0]        sub_idx;
    logic              legal;
    logic              has_sub;
    logic              sub_blocked;

    // Work out range membership and subregion blocking for this region.
    always_comb begin
        hi_shift    = {1'b0, size} + 1'b1;
        upper_diff  = (addr ^ base) >> hi_shift;
        sub_idx     = 3'(addr >> (size - 5'd2));
        legal       = size >= SIZE_MIN;
        has_sub     = size >= SUBREG_MIN;
        sub_blocked = has_sub && subdis[sub_idx];
        hit         = en && legal && (upper_diff == '0) && !sub_blocked;
    end

endmodule

// File: rtl/mpu_priority_pick.sv
// Chooses the highest-numbered asserted hit. Reports whether any hit
// exists and the index of the winner (0 when none).
module mpu_priority_pick #(
    parameter int NUM_REGIONS = 8,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hits,
    output logic                   any_hit,
    output logic [IDX_W-1:0]       win_idx
);

    // Scan upward so the last (highest) hit overrides earlier ones.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                any_hit = 1'b1;
                win_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/mpu_region_guard.sv
// Top of the memory protection region checker. Holds global control bits
// and the region table, matches each presented access against all regions
// in parallel, applies the winning region's permissions and registers the
// verdict for one-cycle latency. Assumes NUM_REGIONS is 8 or 16.
module mpu_region_guard
    import mpu_pkg::*;
#(
    parameter int NUM_REGIONS = 8,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctl_we,
    input  logic                 ctl_unit_en,
    input  logic                 ctl_bg_en,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic                 cfg_en,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic [4:0]           cfg_size,
    input  logic [7:0]           cfg_subdis,
    input  logic [3:0]           cfg_perm,
    input  logic                 cfg_xn,
    input  logic                 acc_valid,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [1:0]           acc_type,
    input  logic                 acc_priv,
    output logic                 res_valid,
    output logic                 res_fault,
    output logic                 res_hit,
    output logic [IDX_W-1:0]     res_region
);

    logic unit_en_q;
    logic bg_en_q;

    logic [NUM_REGIONS-1:0]                tbl_en;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0]    tbl_base;
    logic [NUM_REGIONS-1:0][SIZE_W-1:0]    tbl_size;
    logic [NUM_REGIONS-1:0][SUB_COUNT-1:0] tbl_subdis;
    logic [NUM_REGIONS-1:0][PERM_W-1:0]    tbl_perm;
    logic [NUM_REGIONS-1:0]                tbl_xn;

    logic [NUM_REGIONS-1:0] hits;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;

    logic                   fault_d;
    logic                   hit_d;
    logic [IDX_W-1:0]       region_d;

    // Hold the unit enable and background-access control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unit_en_q <= 1'b0;
            bg_en_q   <= 1'b0;
        end else if (ctl_we) begin
            unit_en_q <= ctl_unit_en;
            bg_en_q   <= ctl_bg_en;
        end
    end

    mpu_region_table #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_idx    (cfg_idx),
        .cfg_en     (cfg_en),
        .cfg_base   (cfg_base),
        .cfg_size   (cfg_size),
        .cfg_subdis (cfg_subdis),
        .cfg_perm   (cfg_perm),
        .cfg_xn     (cfg_xn),
        .tbl_en     (tbl_en),
        .tbl_base   (tbl_base),
        .tbl_size   (tbl_size),
        .tbl_subdis (tbl_subdis),
        .tbl_perm   (tbl_perm),
        .tbl_xn     (tbl_xn)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        mpu_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .en     (tbl_en[g]),
            .base   (tbl_base[g]),
            .size   (tbl_size[g]),
            .subdis (tbl_subdis[g]),
            .addr   (acc_addr),
            .hit    (hits[g])
        );
    end

    mpu_priority_pick #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_pick (
        .hits    (hits),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    // Form the verdict from the winning region or the no-match policy.
    always_comb begin
        fault_d  = 1'b0;
        hit_d    = 1'b0;
        region_d = '0;
        if (unit_en_q) begin
            if (any_hit) begin
                hit_d    = 1'b1;
                region_d = win_idx;
                fault_d  = !access_allowed(tbl_perm[win_idx], tbl_xn[win_idx],
                                           acc_priv, acc_type);
            end else begin
                fault_d  = !(acc_priv && bg_en_q);
            end
        end
    end

    // Register the verdict; fault and hit are only raised with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_fault  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '0;
        end else begin
            res_valid  <= acc_valid;
            res_fault  <= acc_valid && fault_d;
            res_hit    <= acc_valid && hit_d;
            res_region <= acc_valid ? region_d : '0;
        end
    end

endmodule

// File: rtl/mpu_region_guard_props.sv
// Protocol and policy properties for mpu_region_guard, attached by bind.
// Observes the access port, the registered result and the unit enable
// and match summary signals inside the top.
module mpu_region_guard_props #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             acc_priv,
    input logic             unit_en,
    input logic             any_hit,
    input logic             res_valid,
    input logic             res_fault,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_region
);

    // R11: the result strobe follows the access strobe by one cycle
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    // R11: no access, no result
    a_r11_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R11: fault and hit stay low without a valid result
    a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_fault && !res_hit));

    // R2: a disabled unit never faults and never reports a hit
    a_r2_disabled_permits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !unit_en) |=> (!res_fault && !res_hit));

    // R10: unprivileged access outside every region faults
    a_r10_user_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && unit_en && !acc_priv && !any_hit) |=> (res_fault && !res_hit));

    // R10: a result without a hit reports region zero
    a_r10_miss_region_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_region == '0));

endmodule

bind mpu_region_guard mpu_region_guard_props #(
    .IDX_W (IDX_W)
) u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_priv   (acc_priv),
    .unit_en    (unit_en_q),
    .any_hit    (any_hit),
    .res_valid  (res_valid),
    .res_fault  (res_fault),
    .res_hit    (res_hit),
    .res_region (res_region)
);

// File: tb/tb_mpu_region_guard.sv
module tb_mpu_region_guard;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 8;
    localparam int AW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctl_we, ctl_unit_en, ctl_bg_en;
    logic          cfg_we, cfg_en, cfg_xn;
    logic [IW-1:0] cfg_idx;
    logic [AW-1:0] cfg_base;
    logic [4:0]    cfg_size;
    logic [7:0]    cfg_subdis;
    logic [3:0]    cfg_perm;
    logic          acc_valid, acc_priv;
    logic [AW-1:0] acc_addr;
    logic [1:0]    acc_type;
    logic          res_valid, res_fault, res_hit;
    logic [IW-1:0] res_region;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench copy of the programmed table
    bit        m_en   [NR];
    bit [31:0] m_base [NR];
    int        m_size [NR];
    bit [7:0]  m_sub  [NR];
    bit [3:0]  m_perm [NR];
    bit        m_xn   [NR];
    bit        m_unit, m_bg;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_region_guard #(.NUM_REGIONS(NR), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_unit_en(ctl_unit_en), .ctl_bg_en(ctl_bg_en),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_base(cfg_base),
        .cfg_size(cfg_size), .cfg_subdis(cfg_subdis), .cfg_perm(cfg_perm), .cfg_xn(cfg_xn),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_type(acc_type), .acc_priv(acc_priv),
        .res_valid(res_valid), .res_fault(res_fault), .res_hit(res_hit), .res_region(res_region)
    );

    // reference model built from the requirements
    function automatic void model(input bit [31:0] addr, input bit [1:0] kind, input bit priv,
                                  output bit f, output bit h, output int reg_n);
        bit found = 0;
        int win = 0;
        f = 0; h = 0; reg_n = 0;
        if (!m_unit) return;                                  // R2
        for (int r = 0; r < NR; r++) begin
            longint unsigned sz, lo, hi;
            int sidx;
            if (!m_en[r] || m_size[r] < 4) continue;          // R3
            sz = 64'd1 << (m_size[r] + 1);
            lo = longint'(m_base[r]) / sz * sz;               // R4
            hi = lo + sz;
            if (longint'(addr) < lo || longint'(addr) >= hi) continue;
            if (m_size[r] >= 7) begin                          // R5 / R6
                sidx = int'((longint'(addr) - lo) / (sz / 8));
                if (m_sub[r][sidx]) continue;
            end
            found = 1; win = r;                                // R7
        end
        if (!found) begin                                      // R10
            f = !(priv && m_bg);
            return;
        end
        h = 1; reg_n = win;
        begin                                                  // R8 / R9
            bit rd = priv ? m_perm[win][0] : m_perm[win][2];
            bit wr = priv ? m_perm[win][1] : m_perm[win][3];
            bit ok;
            if (kind >= 2) ok = rd && !m_xn[win];
            else if (kind == 1) ok = wr;
            else ok = rd;
            f = !ok;
        end
    endfunction

    task automatic set_ctl(input bit u, input bit bg);
        @(negedge clk);
        ctl_we = 1; ctl_unit_en = u; ctl_bg_en = bg;
        @(negedge clk);
        ctl_we = 0;
        m_unit = u; m_bg = bg;
    endtask

    task automatic put_region(input int idx, input bit en, input bit [31:0] base, input int size,
                              input bit [7:0] sub, input bit [3:0] perm, input bit xn);
        @(negedge clk);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_en = en; cfg_base = base;
        cfg_size = 5'(size); cfg_subdis = sub; cfg_perm = perm; cfg_xn = xn;
        @(negedge clk);
        cfg_we = 0;
        m_en[idx] = en; m_base[idx] = base; m_size[idx] = size;
        m_sub[idx] = sub; m_perm[idx] = perm; m_xn[idx] = xn;
    endtask

    task automatic check_acc(input bit [31:0] addr, input bit [1:0] kind, input bit priv,
                             input string req);
        bit ef, eh;
        int er;
        model(addr, kind, priv, ef, eh, er);
        @(negedge clk);
        acc_valid = 1; acc_addr = addr; acc_type = kind; acc_priv = priv;
        @(negedge clk);
        acc_valid = 0;
        total++;
        if (res_valid !== 1'b1 || res_fault !== ef || res_hit !== eh || int'(res_region) != er) begin
            bad++;
            $display("FAIL %s addr=%h type=%0d priv=%0d actual v=%0b f=%0b h=%0b r=%0d expected v=1 f=%0b h=%0b r=%0d",
                     req, addr, kind, priv, res_valid, res_fault, res_hit, res_region, ef, eh, er);
        end
    endtask

    task automatic check_idle(input string req);
        @(negedge clk);
        acc_valid = 0;
        @(negedge clk);
        total++;
        if (res_valid !== 1'b0 || res_fault !== 1'b0 || res_hit !== 1'b0) begin
            bad++;
            $display("FAIL %s idle actual v=%0b f=%0b h=%0b expected v=0 f=0 h=0",
                     req, res_valid, res_fault, res_hit);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; ctl_we = 0; ctl_unit_en = 0; ctl_bg_en = 0;
        cfg_we = 0; cfg_idx = '0; cfg_en = 0; cfg_base = '0; cfg_size = '0;
        cfg_subdis = '0; cfg_perm = '0; cfg_xn = 0;
        acc_valid = 0; acc_addr = '0; acc_type = '0; acc_priv = 0;
        m_unit = 0; m_bg = 0;
        for (int r = 0; r < NR; r++) begin
            m_en[r] = 0; m_base[r] = 0; m_size[r] = 0; m_sub[r] = 0; m_perm[r] = 0; m_xn[r] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        check_idle("R1");
        check_acc(32'h0000_1000, 2'd1, 1'b0, "R1");
        set_ctl(1, 1);
        check_acc(32'h0000_0000, 2'd0, 1'b1, "R1");

        // R2: disabled unit permits everything
        put_region(0, 1, 32'h0000_0000, 15, 8'h00, 4'b0000, 1);
        set_ctl(0, 0);
        check_acc(32'h0000_0100, 2'd1, 1'b0, "R2");
        check_acc(32'h0000_0200, 2'd2, 1'b0, "R2");
        put_region(0, 0, 32'h0, 0, 8'h00, 4'b0000, 0);
        set_ctl(1, 0);

        // R3: size code 3 is inert; size 4 covers 32 bytes
        put_region(1, 1, 32'h0000_0800, 3, 8'h00, 4'b1111, 0);
        check_acc(32'h0000_0800, 2'd0, 1'b0, "R3");
        put_region(1, 1, 32'h0000_1000, 4, 8'h00, 4'b1111, 0);
        check_acc(32'h0000_101F, 2'd0, 1'b0, "R3");
        check_acc(32'h0000_1020, 2'd0, 1'b0, "R3");

        // R4: misaligned base bits are ignored
        put_region(1, 1, 32'h0000_2005, 4, 8'h00, 4'b1111, 0);
        check_acc(32'h0000_2000, 2'd0, 1'b0, "R4");

        // R5: subregion 2 of a 256 byte region blocked
        put_region(2, 1, 32'h0000_4000, 7, 8'b0000_0100, 4'b1111, 0);
        check_acc(32'h0000_4040, 2'd0, 1'b0, "R5");
        check_acc(32'h0000_403F, 2'd0, 1'b0, "R5");
        check_acc(32'h0000_4060, 2'd0, 1'b0, "R5");

        // R6: mask ignored for a 128 byte region
        put_region(3, 1, 32'h0000_5000, 6, 8'hFF, 4'b1111, 0);
        check_acc(32'h0000_5000, 2'd0, 1'b0, "R6");
        check_acc(32'h0000_507F, 2'd0, 1'b0, "R6");

        // R7: higher region overrides lower one
        put_region(1, 1, 32'h0000_6000, 10, 8'h00, 4'b0011, 0);
        put_region(5, 1, 32'h0000_6100, 5, 8'h00, 4'b0100, 0);
        check_acc(32'h0000_6100, 2'd0, 1'b0, "R7");
        check_acc(32'h0000_6200, 2'd0, 1'b0, "R7");

        // R8: permission bit positions per level and type
        put_region(4, 1, 32'h0000_8000, 8, 8'h00, 4'b0110, 0);
        check_acc(32'h0000_8010, 2'd0, 1'b1, "R8");
        check_acc(32'h0000_8010, 2'd1, 1'b1, "R8");
        check_acc(32'h0000_8010, 2'd0, 1'b0, "R8");
        check_acc(32'h0000_8010, 2'd1, 1'b0, "R8");
        check_acc(32'h0000_8010, 2'd2, 1'b1, "R8");

        // R9: execute-never blocks fetch but not read
        put_region(6, 1, 32'h0000_9000, 8, 8'h00, 4'b1111, 1);
        check_acc(32'h0000_9004, 2'd2, 1'b1, "R9");
        check_acc(32'h0000_9004, 2'd3, 1'b0, "R9");
        check_acc(32'h0000_9004, 2'd0, 1'b0, "R9");

        // R10: no-match policy
        check_acc(32'h00F0_0000, 2'd0, 1'b0, "R10");
        check_acc(32'h00F0_0000, 2'd0, 1'b1, "R10");
        set_ctl(1, 1);
        check_acc(32'h00F0_0000, 2'd1, 1'b1, "R10");
        check_acc(32'h00F0_0000, 2'd1, 1'b0, "R10");

        // R11: idle gap after accesses
        check_idle("R11");

        // random tables and accesses against the model (R3..R10)
        for (int b = 0; b < 24; b++) begin
            set_ctl(($urandom % 8) != 0, $urandom % 2);
            for (int r = 0; r < NR; r++)
                put_region(r, ($urandom % 6) != 0, $urandom % 32'h0001_0000,
                           2 + ($urandom % 12), 8'($urandom), 4'($urandom), $urandom % 2);
            for (int k = 0; k < 40; k++) begin
                int r = $urandom % NR;
                longint unsigned sz = 64'd1 << (m_size[r] + 1);
                bit [31:0] a = 32'(longint'(m_base[r]) / sz * sz + ($urandom % (2 * sz)));
                check_acc(a, 2'($urandom), $urandom % 2, "R7 R8 random");
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule